// File: doc/BRIEF.md
# USB Endpoint Buffer Dispatch Unit

This unit makes the per-transaction decision inside a USB 2.0 device serial interface engine, clocked by the UTMI clock. For each token it receives the endpoint number, the direction, the received data PID (OUT only), the endpoint's transactions-per-microframe setting and the endpoint's two buffer descriptors. Each descriptor holds a 15-bit pointer and a shared flag. One cycle later it answers with one of three outcomes: start a data transfer on a chosen buffer with a chosen data PID, answer NAK, or answer ACK while discarding the data.

The two descriptors form a ping-pong pair that is steered by a per-endpoint selector. A pointer of all ones means the buffer is not allocated. A buffer flagged as shared parks the endpoint: the unit raises an interrupt and answers NAK until the CPU releases a per-endpoint hold bit. The data PID is kept in hardware. Ordinary endpoints use a DATA0/DATA1 toggle. High-bandwidth IN endpoints count down the PID within a microframe. A completion strobe reports whether a started transfer succeeded, and a start-of-microframe strobe restarts the high-bandwidth sequence.

Top module: `usb_ep_dispatch`

## Requirements
- R1: A pointer equal to all ones (7FFFh) is never used for a transfer. If the buffer named by the selector is unallocated, the other buffer is used.
- R2: If both pointers are unallocated, the response is NAK (rsp_code 1). No transfer starts and no interrupt is raised.
- R3: If the chosen buffer is shared and the endpoint has not been released, the response is NAK. The first such token sets the endpoint's hold bit and pulses irq with irq_ep. Later tokens answer NAK with no further irq.
- R4: A hold-clear strobe releases a held endpoint, and that endpoint's next token starts the transfer on the shared buffer. A hold-clear strobe for an endpoint whose hold bit is not set has no effect, even in the same cycle as the token that sets it.
- R5: Each token gives exactly one response, with rsp_valid high in the cycle after tok_valid. Out of reset, rsp_valid and irq are low. rsp_code encodings: 0 start, 1 NAK, 2 ACK-and-discard.
- R6: For an IN token with tpm of 1 (0 is treated as 1), the data PID is the endpoint's toggle. The toggle flips only on a completion with done_ok high. PID codes: 0 DATA0, 1 DATA1, 2 DATA2, 3 MDATA.
- R7: An OUT token whose rx PID differs from {0, toggle} is answered ACK (code 2). The selector, toggle and buffers stay unchanged.
- R8: For an IN token with tpm N of 2 or 3, the PID is DATA(N-1) minus the number of successful IN completions since the last sof, floored at DATA0. When sof and a completion fall in the same cycle, sof wins and the count becomes zero.
- R9: A completion with done_ok sets the selector to the buffer other than the one that was used. A completion without done_ok leaves the selector unchanged.
- R10: A token in the same cycle as a completion for the same endpoint is decided on the state before that completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UTMI clock |
| rst_n | input | 1 | Active-low reset |
| tok_valid | input | 1 | Token present |
| tok_ep | input | EPW | Endpoint number |
| tok_in | input | 1 | 1 for IN, 0 for OUT |
| tok_rx_pid | input | 2 | Received data PID (OUT) |
| tok_tpm | input | 2 | Transactions per microframe |
| dsc_ptr0 | input | PTR_W | Buffer 0 pointer |
| dsc_sh0 | input | 1 | Buffer 0 shared flag |
| dsc_ptr1 | input | PTR_W | Buffer 1 pointer |
| dsc_sh1 | input | 1 | Buffer 1 shared flag |
| hold_clr | input | 1 | CPU hold-clear strobe |
| hold_clr_ep | input | EPW | Endpoint to release |
| done_valid | input | 1 | Transfer completion strobe |
| done_ep | input | EPW | Completed endpoint |
| done_ok | input | 1 | Transfer succeeded |
| sof | input | 1 | Start of microframe |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Start / NAK / ACK |
| rsp_pid | output | 2 | Data PID for the transfer |
| rsp_buf | output | 1 | Buffer chosen |
| rsp_ptr | output | PTR_W | Pointer of chosen buffer |
| irq | output | 1 | Hold interrupt pulse |
| irq_ep | output | EPW | Endpoint that raised irq |

## Verification
Two cases can land in the same cycle. A token can arrive together with a hold-clear strobe for an endpoint that is not yet held. A completion can arrive together with either a token or a microframe start. The bench drives each pair in one cycle on purpose. It then judges the outcome from later tokens: a still-parked endpoint answers NAK without irq, the colliding token reports the pre-completion buffer and PID, and the high-bandwidth sequence restarts at DATA2.

// File: rtl/usb_ep_dispatch.sv
module usb_ep_dispatch #(
  parameter int NUM_EP = 4,
  parameter int PTR_W  = 15,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic [EPW-1:0]   tok_ep,
  input  logic             tok_in,
  input  logic [1:0]       tok_rx_pid,
  input  logic [1:0]       tok_tpm,
  input  logic [PTR_W-1:0] dsc_ptr0,
  input  logic             dsc_sh0,
  input  logic [PTR_W-1:0] dsc_ptr1,
  input  logic             dsc_sh1,
  input  logic             hold_clr,
  input  logic [EPW-1:0]   hold_clr_ep,
  input  logic             done_valid,
  input  logic [EPW-1:0]   done_ep,
  input  logic             done_ok,
  input  logic             sof,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic [1:0]       rsp_pid,
  output logic             rsp_buf,
  output logic [PTR_W-1:0] rsp_ptr,
  output logic             irq,
  output logic [EPW-1:0]   irq_ep
);
  localparam logic [PTR_W-1:0] UNALLOC = '1;
  localparam logic [1:0] C_GO = 2'd0, C_NAK = 2'd1, C_ACK = 2'd2;

  logic [NUM_EP-1:0] sel, tog, hold, grant, pend, pbuf, pdir;
  logic [1:0] hbcnt [NUM_EP];

  wire             cur    = sel[tok_ep];
  wire [PTR_W-1:0] p_cur  = cur ? dsc_ptr1 : dsc_ptr0;
  wire [PTR_W-1:0] p_oth  = cur ? dsc_ptr0 : dsc_ptr1;
  wire             ok_cur = p_cur != UNALLOC;
  wire             ok_oth = p_oth != UNALLOC;
  wire             use_b  = ok_cur ? cur : ~cur;
  wire             use_sh = use_b ? dsc_sh1 : dsc_sh0;
  wire             parked = use_sh && !grant[tok_ep];
  wire             mism   = !tok_in && (tok_rx_pid != {1'b0, tog[tok_ep]});

  wire [1:0] n_tx   = (tok_tpm == 2'd0) ? 2'd1 : tok_tpm;
  wire [1:0] first  = n_tx - 2'd1;
  wire [1:0] cnt    = hbcnt[tok_ep];
  wire [1:0] hb_pid = (cnt >= first) ? 2'd0 : first - cnt;
  wire [1:0] in_pid = (n_tx > 2'd1) ? hb_pid : {1'b0, tog[tok_ep]};

  logic [1:0] code;
  always_comb begin
    if (mism)                  code = C_ACK;
    else if (!(ok_cur|ok_oth)) code = C_NAK;
    else if (parked)           code = C_NAK;
    else                       code = C_GO;
  end

  wire go    = tok_valid && (code == C_GO);
  wire raise = tok_valid && !mism && (ok_cur | ok_oth) && parked && !hold[tok_ep];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= C_GO;
      rsp_pid   <= 2'd0;
      rsp_buf   <= 1'b0;
      rsp_ptr   <= '0;
      irq       <= 1'b0;
      irq_ep    <= '0;
      sel <= '0; tog <= '0; hold <= '0; grant <= '0;
      pend <= '0; pbuf <= '0; pdir <= '0;
      for (int i = 0; i < NUM_EP; i++) hbcnt[i] <= 2'd0;
    end else begin
      rsp_valid <= tok_valid;
      rsp_code  <= code;
      rsp_pid   <= tok_in ? in_pid : tok_rx_pid;
      rsp_buf   <= use_b;
      rsp_ptr   <= use_b ? dsc_ptr1 : dsc_ptr0;
      irq       <= raise;
      irq_ep    <= tok_ep;

      if (done_valid && pend[done_ep]) begin
        pend[done_ep] <= 1'b0;
        if (done_ok) begin
          sel[done_ep] <= ~pbuf[done_ep];
          tog[done_ep] <= ~tog[done_ep];
          if (pdir[done_ep] && hbcnt[done_ep] != 2'd2)
            hbcnt[done_ep] <= hbcnt[done_ep] + 2'd1;
        end
      end
      if (sof)
        for (int i = 0; i < NUM_EP; i++) hbcnt[i] <= 2'd0;

      if (hold_clr && hold[hold_clr_ep]) begin
        hold[hold_clr_ep]  <= 1'b0;
        grant[hold_clr_ep] <= 1'b1;
      end
      if (raise) hold[tok_ep] <= 1'b1;

      if (go) begin
        grant[tok_ep] <= 1'b0;
        pend[tok_ep]  <= 1'b1;
        pbuf[tok_ep]  <= use_b;
        pdir[tok_ep]  <= tok_in;
      end
    end
  end
endmodule

// File: rtl/usb_ep_dispatch_chk.sv
module usb_ep_dispatch_chk #(
  parameter int PTR_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tok_valid,
  input logic             tok_in,
  input logic             rsp_valid,
  input logic [1:0]       rsp_code,
  input logic [1:0]       rsp_pid,
  input logic [PTR_W-1:0] rsp_ptr,
  input logic             irq
);
  a_r1_no_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0) |-> (rsp_ptr != {PTR_W{1'b1}}));

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(tok_valid));

  a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'd3));

  a_r3_irq_with_nak: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rsp_valid && rsp_code == 2'd1));

  a_r7_ack_only_out: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd2) |-> !$past(tok_in));

  a_r8_in_pid_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0 && $past(tok_in)) |-> (rsp_pid != 2'd3));
endmodule

bind usb_ep_dispatch usb_ep_dispatch_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_in(tok_in),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pid(rsp_pid),
  .rsp_ptr(rsp_ptr), .irq(irq)
);

// File: tb/usb_ep_dispatch_test.sv
module usb_ep_dispatch_test;
  localparam int NUM_EP = 4;
  localparam int PTR_W  = 15;
  localparam int EPW    = 2;
  localparam int A = 'h100, B = 'h200, F = 'h7fff;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tok_valid, tok_in, dsc_sh0, dsc_sh1, hold_clr, done_valid, done_ok, sof;
  logic [EPW-1:0] tok_ep, hold_clr_ep, done_ep, irq_ep;
  logic [1:0] tok_rx_pid, tok_tpm, rsp_code, rsp_pid;
  logic [PTR_W-1:0] dsc_ptr0, dsc_ptr1, rsp_ptr;
  logic rsp_valid, rsp_buf, irq;

  usb_ep_dispatch #(.NUM_EP(NUM_EP), .PTR_W(PTR_W)) uut (.*);

  typedef struct {
    int code; int pid; int bsel; int ptr; bit irq; int ep; string tag;
  } exp_t;
  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic tok(int ep, bit in_, int rxp, int tpm, int p0, bit s0, int p1, bit s1,
                     int ecode, int epid, int ebuf, bit eirq, string tag);
    exp_t e;
    e.code = ecode; e.pid = epid; e.bsel = ebuf; e.ptr = ebuf ? p1 : p0;
    e.irq = eirq; e.ep = ep; e.tag = tag;
    q.push_back(e);
    tok_valid = 1; tok_ep = EPW'(ep); tok_in = in_; tok_rx_pid = 2'(rxp);
    tok_tpm = 2'(tpm); dsc_ptr0 = PTR_W'(p0); dsc_sh0 = s0;
    dsc_ptr1 = PTR_W'(p1); dsc_sh1 = s1;
    @(negedge clk);
    tok_valid = 0; hold_clr = 0; done_valid = 0; sof = 0;
  endtask

  task automatic cycle();
    @(negedge clk);
    tok_valid = 0; hold_clr = 0; done_valid = 0; sof = 0;
  endtask

  task automatic done(int ep, bit ok);
    done_valid = 1; done_ep = EPW'(ep); done_ok = ok;
    cycle();
  endtask

  task automatic release_ep(int ep);
    hold_clr = 1; hold_clr_ep = EPW'(ep);
    cycle();
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R5 unexpected response code=%0d expected none", rsp_code);
        end else begin
          exp_t e;
          bit bad;
          e = q.pop_front();
          compared++;
          bad = (int'(rsp_code) != e.code) || (irq != e.irq);
          if (e.irq && int'(irq_ep) != e.ep) bad = 1;
          if (e.code == 0 && (int'(rsp_pid) != e.pid || int'(rsp_buf) != e.bsel ||
                              int'(rsp_ptr) != e.ptr)) bad = 1;
          if (bad) begin
            mismatched++;
            $display("FAIL %s: code=%0d pid=%0d buf=%0d ptr=%h irq=%0b expected code=%0d pid=%0d buf=%0d ptr=%h irq=%0b",
                     e.tag, rsp_code, rsp_pid, rsp_buf, rsp_ptr, irq,
                     e.code, e.pid, e.bsel, e.ptr, e.irq);
          end
        end
      end else if (irq) begin
        compared++; mismatched++;
        $display("FAIL R3 irq without response: irq=1 expected 0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tok_valid = 0; tok_ep = 0; tok_in = 0; tok_rx_pid = 0; tok_tpm = 0;
    dsc_ptr0 = 0; dsc_sh0 = 0; dsc_ptr1 = 0; dsc_sh1 = 0;
    hold_clr = 0; hold_clr_ep = 0; done_valid = 0; done_ep = 0; done_ok = 0; sof = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compared++;
    if (rsp_valid !== 1'b0 || irq !== 1'b0) begin
      mismatched++;
      $display("FAIL R5 reset: rsp_valid=%0b irq=%0b expected 0 0", rsp_valid, irq);
    end
    @(negedge clk);

    // R6 / R9: toggle and ping-pong on ep0
    tok(0,1,0,1, A,0,B,0, 0,0,0,0, "R6 first IN DATA0 buf0");
    done(0,0);
    tok(0,1,0,1, A,0,B,0, 0,0,0,0, "R9 failed done keeps buf0 DATA0");
    done(0,1);
    tok(0,1,0,1, A,0,B,0, 0,1,1,0, "R9 flip to buf1 DATA1");
    done(0,1);
    tok(0,1,0,1, A,0,B,0, 0,0,0,0, "R6 toggle back DATA0 buf0");
    done(0,1);

    // R1: current buffer unallocated, use other
    tok(1,1,0,1, F,0,B,0, 0,0,1,0, "R1 skip unallocated buf0");
    // R2: both unallocated
    tok(2,1,0,1, F,0,F,0, 1,0,0,0, "R2 both unallocated NAK");

    // R3 / R4 on ep3 (OUT)
    tok(3,0,0,1, A,1,B,0, 1,0,0,1, "R3 shared buffer NAK with irq");
    tok(3,0,0,1, A,1,B,0, 1,0,0,0, "R3 held NAK no second irq");
    release_ep(3);
    tok(3,0,0,1, A,1,B,0, 0,0,0,0, "R4 released start buf0");
    done(3,1);
    // R7: mismatch (toggle now 1)
    tok(3,0,0,1, A,0,B,1, 2,0,0,0, "R7 PID mismatch ACK");
    tok(3,0,1,1, A,0,B,0, 0,1,1,0, "R7 state unchanged after discard");

    // R4: hold-clear in same cycle as setting token is ignored
    hold_clr = 1; hold_clr_ep = 2;
    tok(2,1,0,1, A,1,B,0, 1,0,0,1, "R4 set hold with same-cycle clear");
    tok(2,1,0,1, A,1,B,0, 1,0,0,0, "R4 early clear ignored");
    release_ep(2);
    tok(2,1,0,1, A,1,B,0, 0,0,0,0, "R4 release then start");

    // R10: token and completion in same cycle (ep0 sel=1 tog=1)
    tok(0,1,0,1, A,0,B,0, 0,1,1,0, "R10 setup start buf1 DATA1");
    done_valid = 1; done_ep = 0; done_ok = 1;
    tok(0,1,0,1, A,0,B,0, 0,1,1,0, "R10 decided on pre-completion state");
    tok(0,1,0,1, A,0,B,0, 0,0,0,0, "R10 completion applied afterwards");

    // R8: high bandwidth IN on ep1
    sof = 1; cycle();
    tok(1,1,0,3, A,0,B,0, 0,2,0,0, "R8 first of three DATA2");
    done(1,1);
    tok(1,1,0,3, A,0,B,0, 0,1,1,0, "R8 second DATA1");
    done(1,1);
    tok(1,1,0,3, A,0,B,0, 0,0,0,0, "R8 third DATA0");
    done(1,1);
    tok(1,1,0,3, A,0,B,0, 0,0,1,0, "R8 floor at DATA0");
    done_valid = 1; done_ep = 1; done_ok = 1; sof = 1; cycle();
    tok(1,1,0,3, A,0,B,0, 0,2,0,0, "R8 sof wins over completion");
    done(1,1);
    sof = 1; cycle();
    tok(1,1,0,2, A,0,B,0, 0,1,1,0, "R8 two per microframe DATA1");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R5 missing responses: %0d pending expected 0", q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule